// File: doc/BRIEF.md
# Byte and Word Memory Access Aligner

This block connects the load/store stage of a pipeline to a data memory that is addressed by whole 32-bit words. It adds a base register value to a sign-extended 16-bit displacement to form the effective address. It presents the word part of that address to the memory combinationally, and it returns the access result one clock later from registers.

For a load, the block picks either the whole returned word or one byte of it. A byte is placed in the low bits of the result and widened by sign extension or by zero extension. For a store, the block produces the write data and a per-byte write-enable mask, so that the memory changes either the whole word or just the addressed byte.

A run-time input chooses how byte offsets map onto the lanes of a word. In big-endian numbering, offset 0 is the most significant byte. In little-endian numbering, offset 0 is the least significant byte. A word access whose address is not a multiple of four is reported as a fault, and a faulting access writes nothing.

Top module: `mem_access_aligner`

## Requirements
- R1: One cycle after a request, `rsp_addr` equals `base_addr` plus `offset` sign-extended to 32 bits (modulo 2^32), and `mem_word_addr` carries bits 31..2 of that sum in the cycle of the request.
- R2: Byte lane selection follows `big_endian`. With byte offset a = address bits 1..0, lane = a when `big_endian` is 0 and lane = 3-a when it is 1, where lane k is bits 8k+7..8k. Example: from word 0x009012A0 at address 1, an unsigned byte load gives 0x00000090 with `big_endian`=1 and 0x00000012 with `big_endian`=0.
- R3: An unsigned byte load (`req_signed`=0) returns the selected byte in bits 7..0 and zeros in bits 31..8.
- R4: A signed byte load (`req_signed`=1) returns the selected byte in bits 7..0, with bits 31..8 all equal to bit 7 of that byte.
- R5: An aligned word load returns `mem_rdata` unchanged, whatever the value of `big_endian`.
- R6: A byte store drives `store_src[7:0]` onto all four lanes of `store_data` and sets exactly one bit of `byte_en`, bit `lane` (R2 numbering). Merging this into a memory word therefore changes only the addressed byte. Example: storing byte 0x90 (big-endian) or 0x12 (little-endian) to address 6 over the word 0xFFFFFFFF gives 0xFFFF90FF or 0xFF12FFFF respectively.
- R7: An aligned word store drives `store_src` unchanged on `store_data`, with `byte_en` = 4'b1111.
- R8: A word access (`req_word`=1) with address bits 1..0 not equal to 0 sets `align_fault`, forces `byte_en` to 0 and forces `load_data` to 0. Byte accesses never fault.
- R9: Results appear in the cycle after the request, from registers. When `rsp_valid` is 0, or the access was a load, `byte_en` is 0. `align_fault` is 0 whenever `rsp_valid` is 0.
- R10: While `rst_n` is low, all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An access is presented this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = whole word, 0 = single byte |
| req_signed | input | 1 | 1 = sign-extend a loaded byte, 0 = zero-extend |
| big_endian | input | 1 | 1 = offset 0 is the most significant byte |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_src | input | 32 | Source register value for stores |
| mem_word_addr | output | 30 | Word address to the memory, in the same cycle as the request |
| mem_rdata | input | 32 | Word read from `mem_word_addr`, in the same cycle |
| rsp_valid | output | 1 | Result registers hold an access result |
| rsp_addr | output | 32 | Effective byte address |
| load_data | output | 32 | Aligned and extended load value |
| store_data | output | 32 | Write data to the memory |
| byte_en | output | 4 | Per-lane write enable |
| align_fault | output | 1 | Misaligned word access |

## Verification
On every cycle, the assertions check the relations that hold whatever the data:
- the address sum;
- the upper-bit shape of zero-extended and sign-extended byte loads;
- a single enable bit for byte stores and byte replication on the write data;
- a full mask for aligned word stores;
- silence of the mask and the result on a fault, and quiet outputs when idle.

Which lane is chosen under each byte order is shown only by the bench's sweeps over every offset, byte order, extension mode and several data words. The same holds for the exact extracted values and for the merged memory words of the worked store example.

// File: rtl/mal_pkg.sv
package mal_pkg;
   typedef enum logic {
      SZ_BYTE = 1'b0,
      SZ_WORD = 1'b1
   } acc_size_e;

   typedef enum logic {
      ORD_LITTLE = 1'b0,
      ORD_BIG    = 1'b1
   } byte_order_e;

   typedef enum logic {
      EXT_ZERO = 1'b0,
      EXT_SIGN = 1'b1
   } ext_mode_e;
endpackage

// File: rtl/mal_addr_gen.sv
module mal_addr_gen #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16
) (
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [OFF_W-1:0]  offset,
   output logic [ADDR_W-1:0] eff_addr
);
   localparam int EXT_W = ADDR_W - OFF_W;

   generate
      if (OFF_W < 1 || OFF_W > ADDR_W) begin : g_bad_off
         $error("mal_addr_gen: OFF_W must lie in 1..ADDR_W");
      end
      if (EXT_W == 0) begin : g_same_width
         assign eff_addr = base_addr + offset;
      end else begin : g_sext
         logic [ADDR_W-1:0] off_ext;
         assign off_ext  = {{EXT_W{offset[OFF_W-1]}}, offset};
         assign eff_addr = base_addr + off_ext;
      end
   endgenerate
endmodule

// File: rtl/mal_lane_decode.sv
module mal_lane_decode #(
   parameter int LANES  = 4,
   parameter int LANE_W = $clog2(LANES)
) (
   input  logic [LANE_W-1:0] byte_offs,
   input  mal_pkg::byte_order_e order,
   output logic [LANES-1:0]  lane_oh
);
   generate
      if (LANES < 2 || (1 << LANE_W) != LANES) begin : g_bad_lanes
         $error("mal_lane_decode: LANES must be a power of two, at least 2");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic hit_le;
         logic hit_be;
         assign hit_le     = (byte_offs == LANE_W'(g));
         assign hit_be     = (byte_offs == LANE_W'(LANES - 1 - g));
         assign lane_oh[g] = (order == mal_pkg::ORD_BIG) ? hit_be : hit_le;
      end
   endgenerate
endmodule

// File: rtl/mal_load_extract.sv
module mal_load_extract #(
   parameter int DATA_W = 32,
   parameter int LANES  = DATA_W / 8
) (
   input  logic [DATA_W-1:0]  rdata,
   input  logic [LANES-1:0]   lane_oh,
   input  mal_pkg::acc_size_e size,
   input  mal_pkg::ext_mode_e ext,
   output logic [DATA_W-1:0]  ldata
);
   localparam int UP_W = DATA_W - 8;

   logic [LANES-1:0][7:0] lane_bytes;
   logic [LANES-1:0][7:0] masked;
   logic [7:0]            picked;
   logic                  fill;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_mask
         assign lane_bytes[g] = rdata[8*g +: 8];
         assign masked[g]     = lane_oh[g] ? lane_bytes[g] : 8'h00;
      end
   endgenerate

   always_comb begin
      picked = 8'h00;
      for (int i = 0; i < LANES; i++) begin
         picked = picked | masked[i];
      end
   end

   assign fill = (ext == mal_pkg::EXT_SIGN) && picked[7];

   always_comb begin
      if (size == mal_pkg::SZ_WORD) begin
         ldata = rdata;
      end else begin
         ldata = {{UP_W{fill}}, picked};
      end
   end
endmodule

// File: rtl/mal_store_pack.sv
module mal_store_pack #(
   parameter int DATA_W = 32,
   parameter int LANES  = DATA_W / 8
) (
   input  logic [DATA_W-1:0]  src,
   input  logic [LANES-1:0]   lane_oh,
   input  mal_pkg::acc_size_e size,
   input  logic               write_en,
   input  logic               misaligned,
   output logic [DATA_W-1:0]  wdata,
   output logic [LANES-1:0]   be
);
   logic [DATA_W-1:0] byte_rep;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_rep
         assign byte_rep[8*g +: 8] = src[7:0];
      end
   endgenerate

   assign wdata = (size == mal_pkg::SZ_WORD) ? src : byte_rep;

   always_comb begin
      if (!write_en || misaligned) begin
         be = '0;
      end else if (size == mal_pkg::SZ_WORD) begin
         be = '1;
      end else begin
         be = lane_oh;
      end
   end
endmodule

// File: rtl/mem_access_aligner.sv
module mem_access_aligner #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int OFF_W  = 16,
   parameter int LANES  = DATA_W / 8,
   parameter int LANE_W = $clog2(LANES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_store,
   input  logic                     req_word,
   input  logic                     req_signed,
   input  logic                     big_endian,
   input  logic [ADDR_W-1:0]        base_addr,
   input  logic [OFF_W-1:0]         offset,
   input  logic [DATA_W-1:0]        store_src,
   output logic [ADDR_W-LANE_W-1:0] mem_word_addr,
   input  logic [DATA_W-1:0]        mem_rdata,
   output logic                     rsp_valid,
   output logic [ADDR_W-1:0]        rsp_addr,
   output logic [DATA_W-1:0]        load_data,
   output logic [DATA_W-1:0]        store_data,
   output logic [LANES-1:0]         byte_en,
   output logic                     align_fault
);
   import mal_pkg::*;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data
         $error("mem_access_aligner: DATA_W must be a multiple of 8, at least 16");
      end
      if (LANES * 8 != DATA_W) begin : g_bad_lanes
         $error("mem_access_aligner: LANES must equal DATA_W/8");
      end
      if (ADDR_W <= LANE_W) begin : g_bad_addr
         $error("mem_access_aligner: ADDR_W too small");
      end
   endgenerate

   logic [ADDR_W-1:0] eff_c;
   logic [LANES-1:0]  lane_oh_c;
   logic [DATA_W-1:0] ldata_c;
   logic [DATA_W-1:0] wdata_c;
   logic [LANES-1:0]  be_c;
   logic              misal_c;
   acc_size_e         size_c;
   byte_order_e       order_c;
   ext_mode_e         ext_c;

   assign size_c  = req_word   ? SZ_WORD  : SZ_BYTE;
   assign order_c = big_endian ? ORD_BIG  : ORD_LITTLE;
   assign ext_c   = req_signed ? EXT_SIGN : EXT_ZERO;

   mal_addr_gen #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W)
   ) addr_i (
      .base_addr (base_addr),
      .offset    (offset),
      .eff_addr  (eff_c)
   );

   assign mem_word_addr = eff_c[ADDR_W-1:LANE_W];
   assign misal_c       = (size_c == SZ_WORD) && (eff_c[LANE_W-1:0] != '0);

   mal_lane_decode #(
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) lane_i (
      .byte_offs (eff_c[LANE_W-1:0]),
      .order     (order_c),
      .lane_oh   (lane_oh_c)
   );

   mal_load_extract #(
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) load_i (
      .rdata   (mem_rdata),
      .lane_oh (lane_oh_c),
      .size    (size_c),
      .ext     (ext_c),
      .ldata   (ldata_c)
   );

   mal_store_pack #(
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) store_i (
      .src        (store_src),
      .lane_oh    (lane_oh_c),
      .size       (size_c),
      .write_en   (req_valid && req_store),
      .misaligned (misal_c),
      .wdata      (wdata_c),
      .be         (be_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_addr    <= '0;
         load_data   <= '0;
         store_data  <= '0;
         byte_en     <= '0;
         align_fault <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_addr    <= eff_c;
            load_data   <= misal_c ? '0 : ldata_c;
            store_data  <= wdata_c;
            byte_en     <= be_c;
            align_fault <= misal_c;
         end else begin
            byte_en     <= '0;
            align_fault <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mal_checker.sv
module mal_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int OFF_W  = 16,
   parameter int LANES  = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_store,
   input logic              req_word,
   input logic              req_signed,
   input logic [ADDR_W-1:0] base_addr,
   input logic [OFF_W-1:0]  offset,
   input logic [DATA_W-1:0] store_src,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic [DATA_W-1:0] load_data,
   input logic [DATA_W-1:0] store_data,
   input logic [LANES-1:0]  byte_en,
   input logic              align_fault
);
   logic [ADDR_W-1:0] sum_ref;
   logic              byte_load;
   logic              byte_store;
   logic              word_store;

   assign sum_ref    = base_addr + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
   assign byte_load  = req_valid && !req_store && !req_word;
   assign byte_store = req_valid && req_store && !req_word;
   assign word_store = req_valid && req_store && req_word;

   AST_ADDR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_addr == $past(sum_ref)); // R1

   AST_ZERO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(byte_load && !req_signed)) |-> load_data[DATA_W-1:8] == '0); // R3

   AST_SIGN_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(byte_load && req_signed)) |-> load_data[DATA_W-1:8] == {(DATA_W-8){load_data[7]}}); // R4

   AST_BYTE_STORE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(byte_store)) |-> $countones(byte_en) == 1); // R6

   AST_BYTE_STORE_REPL: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(byte_store)) |-> store_data == {LANES{$past(store_src[7:0])}}); // R6

   AST_WORD_STORE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(word_store) && !align_fault) |-> (&byte_en)); // R7

   AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |-> (byte_en == '0 && load_data == '0)); // R8

   AST_FAULT_WORD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |-> $past(req_valid && req_word)); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (byte_en == '0 && !align_fault)); // R9

   AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(!req_store)) |-> byte_en == '0); // R9
endmodule

bind mem_access_aligner mal_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .OFF_W  (OFF_W),
   .LANES  (LANES)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_store   (req_store),
   .req_word    (req_word),
   .req_signed  (req_signed),
   .base_addr   (base_addr),
   .offset      (offset),
   .store_src   (store_src),
   .rsp_valid   (rsp_valid),
   .rsp_addr    (rsp_addr),
   .load_data   (load_data),
   .store_data  (store_data),
   .byte_en     (byte_en),
   .align_fault (align_fault)
);

// File: tb/mem_access_aligner_tb.sv
module mem_access_aligner_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_store = 1'b0, req_word = 1'b0;
   logic        req_signed = 1'b0, big_endian = 1'b0;
   logic [31:0] base_addr = '0;
   logic [15:0] offset = '0;
   logic [31:0] store_src = '0;
   logic [31:0] mem_rdata = '0;
   logic [29:0] mem_word_addr;
   logic        rsp_valid;
   logic [31:0] rsp_addr, load_data, store_data;
   logic [3:0]  byte_en;
   logic        align_fault;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   mem_access_aligner dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_word(req_word), .req_signed(req_signed), .big_endian(big_endian),
      .base_addr(base_addr), .offset(offset), .store_src(store_src),
      .mem_word_addr(mem_word_addr), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .load_data(load_data),
      .store_data(store_data), .byte_en(byte_en), .align_fault(align_fault)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   function automatic int lane_of(input logic [1:0] a, input logic be);
      return be ? 3 - int'(a) : int'(a);
   endfunction

   // drive at a falling edge, result is checked at the next falling edge
   task automatic issue(input logic st, input logic wd, input logic sg, input logic be,
                        input logic [31:0] b, input logic [15:0] o,
                        input logic [31:0] src, input logic [31:0] rd);
      req_valid = 1'b1; req_store = st; req_word = wd; req_signed = sg;
      big_endian = be; base_addr = b; offset = o; store_src = src; mem_rdata = rd;
      #1;
      chk("R1", "mem_word_addr", {2'b00, mem_word_addr},
          {2'b00, 30'((b + {{16{o[15]}}, o}) >> 2)});
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] words [3];
      words[0] = 32'h009012A0;
      words[1] = 32'h80FF7F01;
      words[2] = 32'hDEADBEEF;

      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
      chk("R10", "load_data", load_data, 32'd0);
      chk("R10", "store_data", store_data, 32'd0);
      chk("R10", "byte_en", {28'd0, byte_en}, 32'd0);
      chk("R10", "align_fault", {31'd0, align_fault}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: idle outputs and one-cycle latency
      chk("R9", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
      req_valid = 1'b1; req_store = 1'b1; req_word = 1'b1; base_addr = 32'h40; offset = 16'h0;
      #1;
      chk("R9", "valid before edge", {31'd0, rsp_valid}, 32'd0);
      chk("R9", "byte_en before edge", {28'd0, byte_en}, 32'd0);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9", "valid after edge", {31'd0, rsp_valid}, 32'd1);
      @(negedge clk);
      chk("R9", "idle after request", {31'd0, rsp_valid}, 32'd0);
      chk("R9", "idle byte_en", {28'd0, byte_en}, 32'd0);
      chk("R9", "idle fault", {31'd0, align_fault}, 32'd0);

      // R2 worked example
      issue(1'b0, 1'b0, 1'b0, 1'b1, 32'h0, 16'h0001, 32'h0, 32'h009012A0);
      chk("R2", "example big", load_data, 32'h00000090);
      issue(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 16'h0001, 32'h0, 32'h009012A0);
      chk("R2", "example little", load_data, 32'h00000012);

      // byte load sweep: R1 R2 R3 R4 R8 R9
      for (int w = 0; w < 3; w++)
         for (int be = 0; be < 2; be++)
            for (int sg = 0; sg < 2; sg++)
               for (int a = 0; a < 4; a++)
                  for (int neg = 0; neg < 2; neg++) begin
                     logic [31:0] b, ea, exp;
                     logic [15:0] o;
                     logic [7:0]  by;
                     b = neg ? 32'h2000_0010 + 32'(a) + 32'd8 : 32'h1000_0000;
                     o = neg ? 16'hFFF8 : 16'(a);
                     ea = b + {{16{o[15]}}, o};
                     by = words[w][8*lane_of(ea[1:0], be[0]) +: 8];
                     exp = (sg != 0) ? {{24{by[7]}}, by} : {24'd0, by};
                     issue(1'b0, 1'b0, sg[0], be[0], b, o, 32'h0, words[w]);
                     chk("R1", "rsp_addr", rsp_addr, ea);
                     chk(sg != 0 ? "R4" : "R3", "byte load", load_data, exp);
                     chk("R9", "load byte_en", {28'd0, byte_en}, 32'd0);
                     chk("R8", "byte never faults", {31'd0, align_fault}, 32'd0);
                  end

      // byte store sweep: R2 R6
      for (int be = 0; be < 2; be++)
         for (int a = 0; a < 4; a++) begin
            logic [31:0] src;
            src = 32'hA5C3_3C00 | 32'(8'h11 * (a + 1));
            issue(1'b1, 1'b0, 1'b0, be[0], 32'h300, 16'(a), src, 32'h0);
            chk("R6", "byte store data", store_data, {4{src[7:0]}});
            chk("R6", "byte store enable", {28'd0, byte_en},
                32'd1 << lane_of(2'(a), be[0]));
         end

      // R6 merge example: byte at address 6 over 0xFFFFFFFF
      for (int be = 0; be < 2; be++) begin
         logic [31:0] merged, src;
         src = be ? 32'h90 : 32'h12;
         issue(1'b1, 1'b0, 1'b0, be[0], 32'h0, 16'h0006, src, 32'h0);
         merged = 32'hFFFF_FFFF;
         for (int k = 0; k < 4; k++)
            if (byte_en[k]) merged[8*k +: 8] = store_data[8*k +: 8];
         chk("R6", be ? "merge big" : "merge little", merged,
             be ? 32'hFFFF90FF : 32'hFF12FFFF);
      end

      // word access sweep: R5 R7 R8
      for (int be = 0; be < 2; be++)
         for (int a = 0; a < 4; a++) begin
            issue(1'b0, 1'b1, 1'b1, be[0], 32'h500 + 32'(a), 16'h0, 32'h0, 32'h8765_4321);
            chk(a == 0 ? "R5" : "R8", "word load", load_data, a == 0 ? 32'h8765_4321 : 32'h0);
            chk("R8", "load fault", {31'd0, align_fault}, a == 0 ? 32'd0 : 32'd1);
            issue(1'b1, 1'b1, 1'b0, be[0], 32'h600, 16'(a), 32'hCAFE_F00D, 32'h0);
            chk("R7", "word store data", store_data, 32'hCAFE_F00D);
            chk(a == 0 ? "R7" : "R8", "word store enable", {28'd0, byte_en},
                a == 0 ? 32'hF : 32'h0);
            chk("R8", "store fault", {31'd0, align_fault}, a == 0 ? 32'd0 : 32'd1);
         end

      // R10: reset mid-run clears outputs
      issue(1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 16'h0, 32'h1234_5678, 32'h0);
      rst_n = 1'b0;
      #1;
      chk("R10", "reset clears enable", {28'd0, byte_en}, 32'd0);
      chk("R10", "reset clears data", store_data, 32'd0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule